// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block is the interlock controller for a five-stage in-order pipeline whose branches compare registers and pick their target while still in the decode stage. Forwarding already covers ALU results consumed in the execute stage. This unit catches the cases that forwarding cannot reach. It then holds the front of the pipeline and injects no-op bubbles until the needed value can be delivered.

Each cycle the unit looks at four things: the two source register numbers of the instruction in decode, the destination and type of the instruction in execute, the destination and type of the instruction in the memory stage, and whether decode holds a branch and whether that branch resolves taken. A branch that waits on a value needs one or two hold cycles, depending on how far back the producing instruction is and whether it is a load. A small counter sustains the two-cycle case. A taken branch that is not held flushes the single instruction fetched behind it.

Top module: `hz_stall_unit`

## Requirements
- R1: When the execute-stage instruction reads memory (`ex_mem_rd`=1) and its destination is nonzero and equals either decode source register, the unit stalls that cycle, whether or not decode holds a branch.
- R2: A destination register number of zero, in either stage, never causes a stall.
- R3: In a stall cycle `pc_we`=0, `ifd_we`=0 and `idex_bubble`=1. In every other cycle `pc_we`=1, `ifd_we`=1 and `idex_bubble`=0.
- R4: An execute-stage ALU writer (`ex_reg_wr`=1, `ex_mem_rd`=0) whose nonzero destination matches a decode source stalls only when `dec_branch`=1. That stall lasts one cycle, so the next cycle with no hazard on the inputs is not stalled.
- R5: With `dec_branch`=1, a memory-stage load (`mem_mem_rd`=1 and `mem_reg_wr`=1) whose nonzero destination matches a decode source stalls. A memory-stage ALU writer (`mem_mem_rd`=0) never stalls.
- R6: With `dec_branch`=1 and an execute-stage load matching a decode source, while no hold is pending, the unit stalls that cycle and also the next `LOAD_BR_STALLS`-1 cycles (1 by default), whatever the inputs are in those cycles.
- R7: `ifd_flush`=1 exactly when `dec_branch`=1, `br_taken`=1 and the cycle is not a stall.
- R8: When a stall and a taken branch occur in the same cycle, the stall wins and `ifd_flush`=0.
- R9: After reset no hold is pending, so an idle input pattern gives `pc_we`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| dec_branch | input | 1 | Decode holds a branch |
| br_taken | input | 1 | Branch compare in decode resolves taken |
| ex_mem_rd | input | 1 | Execute-stage instruction is a load |
| ex_reg_wr | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_W | Execute-stage destination register |
| mem_mem_rd | input | 1 | Memory-stage instruction is a load |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| pc_we | output | 1 | Program counter write enable |
| ifd_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields entering execute |
| ifd_flush | output | 1 | Turn the fetch/decode instruction into a no-op |

## Verification
The bench targets the cases that are easy to get wrong. A register-zero destination that matches a zero source would cause spurious stalls if the zero check were missing. An execute-stage ALU producer with no branch in decode would stall needlessly if the branch qualifier were dropped, and a memory-stage ALU producer would stall a branch that forwarding already serves. The load-before-branch case is driven with idle inputs in the second cycle, so a design without the hold counter releases the pipeline one cycle early. Stalled taken branches are also driven, where a design that puts the flush first would discard the branch's successor before the branch had resolved.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // nonzero destination that matches one of two source registers
  function automatic logic dst_hits(input logic [7:0] dst, input logic [7:0] sa,
                                    input logic [7:0] sb);
    return (dst != 8'd0) && ((dst == sa) || (dst == sb));
  endfunction
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             ex_mem_rd,
  input  logic [REG_W-1:0] ex_dst,
  output logic             ex_hit,
  output logic             lu_hazard
);
  import hz_pkg::*;
  always_comb begin
    ex_hit    = dst_hits(8'(ex_dst), 8'(src_a), 8'(src_b));
    lu_hazard = ex_mem_rd && ex_hit;
  end
endmodule

// File: rtl/hz_branch_dep.sv
module hz_branch_dep #(
  parameter int REG_W = 5
) (
  input  logic             dec_branch,
  input  logic             ex_hit,
  input  logic             ex_mem_rd,
  input  logic             ex_reg_wr,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             mem_mem_rd,
  input  logic             mem_reg_wr,
  input  logic [REG_W-1:0] mem_dst,
  output logic             br_one,
  output logic             br_two
);
  import hz_pkg::*;
  logic mem_hit;
  always_comb begin
    mem_hit = dst_hits(8'(mem_dst), 8'(src_a), 8'(src_b));
    // one cycle: ALU result one back, or load two back
    br_one  = dec_branch && ((ex_reg_wr && !ex_mem_rd && ex_hit) ||
                             (mem_mem_rd && mem_reg_wr && mem_hit));
    // load directly ahead of the branch
    br_two  = dec_branch && ex_mem_rd && ex_hit;
  end
endmodule

// File: rtl/hz_hold_seq.sv
module hz_hold_seq #(
  parameter int LOAD_BR_STALLS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic hold
);
  localparam int CNT_W = (LOAD_BR_STALLS > 2) ? $clog2(LOAD_BR_STALLS) : 1;
  localparam logic [CNT_W-1:0] EXTRA = CNT_W'(LOAD_BR_STALLS - 1);
  logic [CNT_W-1:0] cnt_q;

  assign hold = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (hold)   cnt_q <= cnt_q - 1'b1;
    else if (start)  cnt_q <= EXTRA;
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_W          = 5,
  parameter int LOAD_BR_STALLS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_branch,
  input  logic             br_taken,
  input  logic             ex_mem_rd,
  input  logic             ex_reg_wr,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_mem_rd,
  input  logic             mem_reg_wr,
  input  logic [REG_W-1:0] mem_dst,
  output logic             pc_we,
  output logic             ifd_we,
  output logic             idex_bubble,
  output logic             ifd_flush
);
  logic ex_hit, lu_hazard, br_one, two_cyc_hit, hold_q, stall_now;

  hz_load_use #(.REG_W(REG_W)) lu_i (
    .src_a(dec_src_a), .src_b(dec_src_b), .ex_mem_rd(ex_mem_rd),
    .ex_dst(ex_dst), .ex_hit(ex_hit), .lu_hazard(lu_hazard)
  );

  hz_branch_dep #(.REG_W(REG_W)) br_i (
    .dec_branch(dec_branch), .ex_hit(ex_hit), .ex_mem_rd(ex_mem_rd),
    .ex_reg_wr(ex_reg_wr), .src_a(dec_src_a), .src_b(dec_src_b),
    .mem_mem_rd(mem_mem_rd), .mem_reg_wr(mem_reg_wr), .mem_dst(mem_dst),
    .br_one(br_one), .br_two(two_cyc_hit)
  );

  hz_hold_seq #(.LOAD_BR_STALLS(LOAD_BR_STALLS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(two_cyc_hit), .hold(hold_q)
  );

  always_comb begin
    stall_now   = hold_q || lu_hazard || br_one || two_cyc_hit;
    pc_we       = !stall_now;
    ifd_we      = !stall_now;
    idex_bubble = stall_now;
    ifd_flush   = dec_branch && br_taken && !stall_now;
  end
endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic             dec_branch,
  input logic             br_taken,
  input logic             ex_mem_rd,
  input logic [REG_W-1:0] ex_dst,
  input logic             pc_we,
  input logic             ifd_we,
  input logic             idex_bubble,
  input logic             ifd_flush,
  input logic             hold_q,
  input logic             two_cyc_hit
);
  // R3
  stall_ctrl_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifd_we) && (idex_bubble == !pc_we));
  // R1
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_dst != '0 && (ex_dst == dec_src_a || ex_dst == dec_src_b))
      |-> idex_bubble);
  // R6
  two_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_cyc_hit && !hold_q) |=> idex_bubble);
  // R8
  stall_over_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifd_flush |-> !idex_bubble);
  // R7
  taken_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_branch && br_taken && !idex_bubble) |-> ifd_flush);
endmodule

bind hz_stall_unit hz_stall_unit_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/hz_stall_unit_tb.sv
module hz_stall_unit_tb_top;
  localparam int RW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] sa, sb, exd, memd;
  logic br, tk, exr, exw, mr, mw;
  logic pc_we, ifd_we, bub, flush;
  int checks = 0, fails = 0, pend = 0;

  always #4 clk = ~clk;

  hz_stall_unit #(.REG_W(RW), .LOAD_BR_STALLS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_src_a(sa), .dec_src_b(sb), .dec_branch(br),
    .br_taken(tk), .ex_mem_rd(exr), .ex_reg_wr(exw), .ex_dst(exd),
    .mem_mem_rd(mr), .mem_reg_wr(mw), .mem_dst(memd),
    .pc_we(pc_we), .ifd_we(ifd_we), .idex_bubble(bub), .ifd_flush(flush));

  function automatic bit hit(input logic [RW-1:0] d);
    if (d == 0) return 0;
    return (d == sa) || (d == sb);
  endfunction
  function automatic bit two_now();
    return br && exr && hit(exd);
  endfunction
  function automatic bit exp_stall();
    if (pend != 0) return 1;
    if (exr && hit(exd)) return 1;
    if (br && exw && !exr && hit(exd)) return 1;
    if (br && mr && mw && hit(memd)) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input int b, input bit ibr, input bit itk,
                     input bit ier, input bit iew, input int ied,
                     input bit imr, input bit imw, input int imd);
    @(negedge clk);
    sa = RW'(a); sb = RW'(b); br = ibr; tk = itk; exr = ier; exw = iew;
    exd = RW'(ied); mr = imr; mw = imw; memd = RW'(imd);
    #1;
  endtask

  task automatic advance();
    int nxt;
    nxt = (pend != 0) ? pend - 1 : (two_now() ? 1 : 0);
    @(posedge clk);
    pend = nxt;
  endtask

  task automatic check_all(input string tag);
    bit s;
    s = exp_stall();
    chk({tag, " R3 pc_we"}, pc_we, !s);
    chk({tag, " R3 ifd_we"}, ifd_we, !s);
    chk({tag, " R3 bubble"}, bub, s);
    chk({tag, " R7 flush"}, flush, br && tk && !s);
  endtask

  initial begin
    fork
      begin
        sa = 0; sb = 0; br = 0; tk = 0; exr = 0; exw = 0; exd = 0;
        mr = 0; mw = 0; memd = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 idle after reset
        put(1, 2, 0, 0, 0, 0, 0, 0, 0, 0); chk("R9 pc_we after reset", pc_we, 1); advance();
        // R1 load-use on each source
        put(3, 4, 0, 0, 1, 1, 3, 0, 0, 0); chk("R1 match a", bub, 1); advance();
        put(3, 4, 0, 0, 1, 1, 4, 0, 0, 0); chk("R1 match b", bub, 1); advance();
        // R2 zero destinations
        put(0, 0, 1, 0, 1, 1, 0, 1, 1, 0); chk("R2 zero dst", bub, 0); advance();
        put(0, 5, 1, 0, 0, 1, 0, 0, 0, 0); chk("R2 zero alu dst", pc_we, 1); advance();
        // R4 ALU one back
        put(6, 7, 0, 0, 0, 1, 6, 0, 0, 0); chk("R4 alu no branch", bub, 0); advance();
        put(6, 7, 1, 1, 0, 1, 6, 0, 0, 0); chk("R4 alu branch", bub, 1);
        chk("R8 flush held", flush, 0); advance();
        put(6, 7, 1, 1, 0, 0, 0, 0, 0, 0); chk("R4 released", bub, 0);
        chk("R7 taken flush", flush, 1); advance();
        // R5 memory stage producers
        put(8, 9, 1, 0, 0, 0, 0, 1, 1, 9); chk("R5 load two back", bub, 1); advance();
        put(8, 9, 1, 0, 0, 0, 0, 0, 1, 9); chk("R5 alu two back", bub, 0); advance();
        // R6 load directly ahead of branch
        put(10, 11, 1, 1, 1, 1, 10, 0, 0, 0); chk("R6 first", bub, 1); advance();
        put(1, 2, 0, 0, 0, 0, 0, 0, 0, 0); chk("R6 second idle", bub, 1);
        chk("R6 pc held", pc_we, 0); advance();
        put(1, 2, 0, 0, 0, 0, 0, 0, 0, 0); chk("R6 third", bub, 0); advance();
        put(1, 2, 1, 0, 0, 0, 0, 0, 0, 0); chk("R7 not taken", flush, 0); advance();
        // random mix
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
          put($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
              ($urandom % 3) == 0, $urandom % 2, $urandom % 4,
              ($urandom % 3) == 0, $urandom % 2, $urandom % 4);
          check_all($sformatf("rand%0d", i));
          advance();
        end
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R3 actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule